// File: doc/BRIEF.md
# Superscalar Issue Grouping Unit

This block looks at the three oldest decoded instructions of an instruction queue in each cycle. It decides how many of them leave together as one execution group. Each slot comes with a descriptor: a valid bit, a class code, one destination register with a write flag, two source registers and two address-generation registers (each with its own valid bit), a flag for instructions that can report overflow in the condition code, and a flag for load-and-test. A single program-status input enables overflow exceptions.

The block decides once per cycle and registers the result. The outputs are the group size, per-slot issue enables, per-source forwarding selects that name the producing slot, and a flag for condition-code forwarding. Slots are judged strictly in age order. The first slot that breaks a rule closes the group, and no younger slot may pass it. The queue control uses the group size to pop entries. The execution dataflow uses the selects to steer a loaded value into a same-group consumer.

Top module: `issue_grouper`

## Requirements
- R1: While reset is held, and in the cycle after an input set whose oldest slot (slot 0) is invalid, the outputs are zero: group size 0, no issue enables, no forwarding selects, no condition-code forwarding.
- R2: Outputs are registered. The inputs present at a rising edge determine the outputs from that edge onward. The group size equals the number of issue enables, and the enables are contiguous from slot 0.
- R3: A group has at most three members. A branch (class code 3) may only be slot 0, so branch plus two simple instructions forms a full group. A branch in slot 1 or 2 ends the group before it.
- R4: A group holds at most one store (class code 2). A second store ends the group before it. Loads and stores mix freely otherwise.
- R5: A younger slot is refused when either of its valid address-generation registers equals the destination of an older group member that writes a register.
- R6: A younger slot that reads, as a valid source, a register written by an older member is refused unless R7 or R8 applies. The producer considered is the youngest older member that writes that register.
- R7: When that producer is a plain load (class code 1), the slot joins and forwarding-select bit (slot*2 + source)*3 + producer is set. Selects are only ever set for issued slots.
- R8: When the producer can report overflow, the reader is a load-and-test, and the overflow-exception input is low, the slot joins and the condition-code forwarding output is set.
- R9: With the overflow-exception input high, the pair of R8 is split into separate groups and condition-code forwarding stays low.
- R10: Class code 4 (complex) and the unused codes 5 to 7 issue alone. In slot 0 such an instruction gives group size 1, and in a younger slot it ends the group before it.
- R11: An invalid slot or a refused slot ends the group. A valid younger slot behind it is not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 3 | Slot valid, bit k for slot k (slot 0 oldest) |
| in_cls | input | 9 | Class code per slot, 3 bits each |
| in_dst | input | 12 | Destination register per slot, 4 bits each |
| in_wr | input | 3 | Slot writes its destination register |
| in_src | input | 24 | Source registers, field (slot*2+source) of 4 bits |
| in_srcv | input | 6 | Source valid, bit slot*2+source |
| in_agr | input | 24 | Address-generation registers, field (slot*2+index) of 4 bits |
| in_agrv | input | 6 | Address-generation register valid, bit slot*2+index |
| in_ovf | input | 3 | Slot can report overflow in the condition code |
| in_ldt | input | 3 | Slot is a load-and-test |
| ovf_trap_en | input | 1 | Program-status overflow-exception enable |
| grp_size | output | 2 | Number of instructions in the issued group |
| issue_en | output | 3 | Per-slot issue enable |
| fwd_sel | output | 18 | Forwarding select, bit (slot*2+source)*3+producer |
| cc_fwd | output | 1 | Group condition code taken from sign and zero with overflow suppressed |

## Verification
On every cycle, the assertions check the group that is about to be registered. They check that an empty oldest slot yields an empty group, that the enables form a prefix that matches the size, that no younger issued slot is a branch, and that no group holds two stores. They also check that a lone complex instruction has size one, that no issued slot has an address-generation conflict with an older member, that condition-code forwarding never coexists with the exception enable, and that selects appear only on issued slots. Several things depend on the exact register numbers and classes chosen, so only the bench scenarios show them. These are whether a dependency is forwarded or refused, which producer is picked when two older members write the same register, and how the condition-code pair splits when the exception enable is set. The bench's reference model covers them with directed cases and random descriptors over a small register range.

// File: rtl/grp_pkg.sv
package grp_pkg;

  typedef logic [2:0] cls_t;

  localparam cls_t CLS_SIMPLE  = 3'd0;
  localparam cls_t CLS_LOAD    = 3'd1;
  localparam cls_t CLS_STORE   = 3'd2;
  localparam cls_t CLS_BRANCH  = 3'd3;
  localparam cls_t CLS_COMPLEX = 3'd4;

  localparam int CLS_W = 3;

  // complex and every unassigned code run without companions
  function automatic logic runs_alone(cls_t c);
    return c >= CLS_COMPLEX;
  endfunction

  function automatic logic is_store(cls_t c);
    return c == CLS_STORE;
  endfunction

  function automatic logic is_branch(cls_t c);
    return c == CLS_BRANCH;
  endfunction

  // only a plain load may hand its result to a same-group consumer
  function automatic logic can_forward(cls_t c);
    return c == CLS_LOAD;
  endfunction

endpackage

// File: rtl/grp_slot_eval.sv
module grp_slot_eval
  import grp_pkg::*;
#(
  parameter int IDX  = 0,
  parameter int N    = 3,
  parameter int NSRC = 2,
  parameter int NAGR = 2,
  parameter int RW   = 4
) (
  // this slot
  input  logic                 vld_k,
  input  cls_t                 cls_k,
  input  logic [NSRC*RW-1:0]   src_k,
  input  logic [NSRC-1:0]      srcv_k,
  input  logic [NAGR*RW-1:0]   agr_k,
  input  logic [NAGR-1:0]      agrv_k,
  input  logic                 ldt_k,
  // all slots, only the older ones are consulted
  input  logic [N*CLS_W-1:0]   cls_all,
  input  logic [N*RW-1:0]      dst_all,
  input  logic [N-1:0]         wr_all,
  input  logic [N-1:0]         ovf_all,
  input  logic                 trap_en,
  // verdict
  output logic                 ok,
  output logic [NSRC*N-1:0]    fwd,
  output logic                 ccf,
  output logic                 cut_br,
  output logic                 cut_alone,
  output logic                 cut_st,
  output logic                 cut_agi,
  output logic                 cut_raw
);

  localparam logic IS_HEAD = (IDX == 0);

  always_comb begin
    cut_br    = is_branch(cls_k);
    cut_alone = runs_alone(cls_k);
    cut_st    = 1'b0;
    cut_agi   = 1'b0;
    cut_raw   = 1'b0;
    ccf       = 1'b0;
    fwd       = '0;

    for (int j = 0; j < N; j++) begin
      if (j < IDX) begin
        if (runs_alone(cls_all[j*CLS_W +: CLS_W]))
          cut_alone = 1'b1;
        if (is_store(cls_all[j*CLS_W +: CLS_W]) && is_store(cls_k))
          cut_st = 1'b1;
        for (int a = 0; a < NAGR; a++) begin
          if (agrv_k[a] && wr_all[j] &&
              dst_all[j*RW +: RW] == agr_k[a*RW +: RW])
            cut_agi = 1'b1;
        end
      end
    end

    for (int s = 0; s < NSRC; s++) begin
      logic hit;
      int   prod;
      hit  = 1'b0;
      prod = 0;
      // scanning upward leaves the youngest writer as producer
      for (int j = 0; j < N; j++) begin
        if (j < IDX && srcv_k[s] && wr_all[j] &&
            dst_all[j*RW +: RW] == src_k[s*RW +: RW]) begin
          hit  = 1'b1;
          prod = j;
        end
      end
      if (hit) begin
        if (can_forward(cls_all[prod*CLS_W +: CLS_W]))
          fwd[s*N + prod] = 1'b1;
        else if (ldt_k && ovf_all[prod] && !trap_en)
          ccf = 1'b1;
        else
          cut_raw = 1'b1;
      end
    end

    ok = vld_k & (IS_HEAD | ~(cut_br | cut_alone | cut_st | cut_agi | cut_raw));
  end

endmodule

// File: rtl/grp_prefix.sv
module grp_prefix #(
  parameter int N    = 3,
  parameter int MAXG = 3,
  localparam int SZ_W = $clog2(N + 1)
) (
  input  logic [N-1:0]    ok,
  output logic [N-1:0]    en,
  output logic [SZ_W-1:0] size
);

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_chain
      if (k == 0) begin : g_head
        assign en[k] = ok[k];
      end else if (k < MAXG) begin : g_body
        assign en[k] = en[k-1] & ok[k];
      end else begin : g_beyond
        assign en[k] = 1'b0 & ok[k];
      end
    end
  endgenerate

  always_comb begin
    size = '0;
    for (int i = 0; i < N; i++)
      size = size + SZ_W'(en[i]);
  end

endmodule

// File: rtl/grp_hold.sv
module grp_hold #(
  parameter int N    = 3,
  parameter int NSRC = 2,
  localparam int SZ_W  = $clog2(N + 1),
  localparam int SEL_W = N * NSRC * N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SZ_W-1:0]  nxt_size,
  input  logic [N-1:0]     nxt_en,
  input  logic [SEL_W-1:0] nxt_fwd,
  input  logic [N-1:0]     nxt_ccf,
  output logic [SZ_W-1:0]  grp_size,
  output logic [N-1:0]     issue_en,
  output logic [SEL_W-1:0] fwd_sel,
  output logic             cc_fwd
);

  logic [SEL_W-1:0] fwd_masked;

  always_comb begin
    for (int k = 0; k < N; k++)
      fwd_masked[k*NSRC*N +: NSRC*N] = nxt_fwd[k*NSRC*N +: NSRC*N] & {(NSRC*N){nxt_en[k]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_size <= '0;
      issue_en <= '0;
      fwd_sel  <= '0;
      cc_fwd   <= 1'b0;
    end else begin
      grp_size <= nxt_size;
      issue_en <= nxt_en;
      fwd_sel  <= fwd_masked;
      cc_fwd   <= |(nxt_ccf & nxt_en);
    end
  end

endmodule

// File: rtl/issue_grouper.sv
module issue_grouper
  import grp_pkg::*;
#(
  parameter int N    = 3,
  parameter int NSRC = 2,
  parameter int NAGR = 2,
  parameter int RW   = 4,
  parameter int MAXG = 3,
  localparam int SZ_W  = $clog2(N + 1),
  localparam int SEL_W = N * NSRC * N
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          in_vld,
  input  logic [N*CLS_W-1:0]    in_cls,
  input  logic [N*RW-1:0]       in_dst,
  input  logic [N-1:0]          in_wr,
  input  logic [N*NSRC*RW-1:0]  in_src,
  input  logic [N*NSRC-1:0]     in_srcv,
  input  logic [N*NAGR*RW-1:0]  in_agr,
  input  logic [N*NAGR-1:0]     in_agrv,
  input  logic [N-1:0]          in_ovf,
  input  logic [N-1:0]          in_ldt,
  input  logic                  ovf_trap_en,
  output logic [SZ_W-1:0]       grp_size,
  output logic [N-1:0]          issue_en,
  output logic [SEL_W-1:0]      fwd_sel,
  output logic                  cc_fwd
);

  // named internal events, observed by the bound checker
  logic [N-1:0]     slot_ok;
  logic [N-1:0]     slot_ccf;
  logic [N-1:0]     cut_br, cut_alone, cut_st, cut_agi, cut_raw;
  logic [SEL_W-1:0] nxt_fwd;
  logic [N-1:0]     nxt_en;
  logic [SZ_W-1:0]  nxt_size;
  logic             nxt_cc;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_slot
      grp_slot_eval #(
        .IDX (k),
        .N   (N),
        .NSRC(NSRC),
        .NAGR(NAGR),
        .RW  (RW)
      ) u_eval (
        .vld_k    (in_vld[k]),
        .cls_k    (in_cls[k*CLS_W +: CLS_W]),
        .src_k    (in_src[k*NSRC*RW +: NSRC*RW]),
        .srcv_k   (in_srcv[k*NSRC +: NSRC]),
        .agr_k    (in_agr[k*NAGR*RW +: NAGR*RW]),
        .agrv_k   (in_agrv[k*NAGR +: NAGR]),
        .ldt_k    (in_ldt[k]),
        .cls_all  (in_cls),
        .dst_all  (in_dst),
        .wr_all   (in_wr),
        .ovf_all  (in_ovf),
        .trap_en  (ovf_trap_en),
        .ok       (slot_ok[k]),
        .fwd      (nxt_fwd[k*NSRC*N +: NSRC*N]),
        .ccf      (slot_ccf[k]),
        .cut_br   (cut_br[k]),
        .cut_alone(cut_alone[k]),
        .cut_st   (cut_st[k]),
        .cut_agi  (cut_agi[k]),
        .cut_raw  (cut_raw[k])
      );
    end
  endgenerate

  grp_prefix #(
    .N   (N),
    .MAXG(MAXG)
  ) u_prefix (
    .ok  (slot_ok),
    .en  (nxt_en),
    .size(nxt_size)
  );

  assign nxt_cc = |(slot_ccf & nxt_en);

  grp_hold #(
    .N   (N),
    .NSRC(NSRC)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .nxt_size(nxt_size),
    .nxt_en  (nxt_en),
    .nxt_fwd (nxt_fwd),
    .nxt_ccf (slot_ccf),
    .grp_size(grp_size),
    .issue_en(issue_en),
    .fwd_sel (fwd_sel),
    .cc_fwd  (cc_fwd)
  );

endmodule

// File: rtl/grp_checks.sv
module grp_checks
  import grp_pkg::*;
#(
  parameter int N    = 3,
  parameter int NSRC = 2,
  parameter int NAGR = 2,
  parameter int RW   = 4,
  localparam int SZ_W  = $clog2(N + 1),
  localparam int SEL_W = N * NSRC * N
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         in_vld,
  input logic [N*CLS_W-1:0]   in_cls,
  input logic [N*RW-1:0]      in_dst,
  input logic [N-1:0]         in_wr,
  input logic [N*NAGR*RW-1:0] in_agr,
  input logic [N*NAGR-1:0]    in_agrv,
  input logic                 ovf_trap_en,
  input logic [N-1:0]         nxt_en,
  input logic [SZ_W-1:0]      nxt_size,
  input logic                 nxt_cc,
  input logic [N-1:0]         issue_en,
  input logic [SEL_W-1:0]     fwd_sel
);

  logic [N-1:0] store_mask;
  logic         agi_bad;

  always_comb begin
    store_mask = '0;
    agi_bad    = 1'b0;
    for (int k = 0; k < N; k++) begin
      store_mask[k] = is_store(in_cls[k*CLS_W +: CLS_W]);
      for (int j = 0; j < k; j++)
        for (int a = 0; a < NAGR; a++)
          if (nxt_en[k] && nxt_en[j] && in_wr[j] && in_agrv[k*NAGR + a] &&
              in_dst[j*RW +: RW] == in_agr[(k*NAGR + a)*RW +: RW])
            agi_bad = 1'b1;
    end
  end

  AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld[0] |-> nxt_en == '0); // R1

  AST_SIZE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_size == SZ_W'($countones(nxt_en))); // R2

  AST_PREFIX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_en & (nxt_en + 1'b1)) == '0); // R11

  AST_SINGLE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(nxt_en & store_mask) <= 1); // R4

  AST_LONE_COMPLEX: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_en[0] && runs_alone(in_cls[CLS_W-1:0])) |-> nxt_size == SZ_W'(1)); // R10

  AST_NO_AGI: assert property (@(posedge clk) disable iff (!rst_n)
    !agi_bad); // R5

  AST_CC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap_en |-> !nxt_cc); // R9

  genvar k;
  generate
    for (k = 1; k < N; k++) begin : g_young
      AST_BRANCH_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_en[k] |-> !is_branch(in_cls[k*CLS_W +: CLS_W])); // R3
    end
    for (k = 0; k < N; k++) begin : g_sel
      AST_SEL_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_en[k] |-> fwd_sel[k*NSRC*N +: NSRC*N] == '0); // R7
    end
  endgenerate

endmodule

bind issue_grouper grp_checks #(
  .N   (N),
  .NSRC(NSRC),
  .NAGR(NAGR),
  .RW  (RW)
) u_grp_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_vld     (in_vld),
  .in_cls     (in_cls),
  .in_dst     (in_dst),
  .in_wr      (in_wr),
  .in_agr     (in_agr),
  .in_agrv    (in_agrv),
  .ovf_trap_en(ovf_trap_en),
  .nxt_en     (nxt_en),
  .nxt_size   (nxt_size),
  .nxt_cc     (nxt_cc),
  .issue_en   (issue_en),
  .fwd_sel    (fwd_sel)
);

// File: tb/issue_grouper_bench.sv
module issue_grouper_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5ns clk = ~clk;

  logic [2:0]  in_vld, in_wr, in_ovf, in_ldt;
  logic [8:0]  in_cls;
  logic [11:0] in_dst;
  logic [23:0] in_src, in_agr;
  logic [5:0]  in_srcv, in_agrv;
  logic        ovf_trap_en;
  logic [1:0]  grp_size;
  logic [2:0]  issue_en;
  logic [17:0] fwd_sel;
  logic        cc_fwd;

  // behavioural slot descriptors
  logic       b_vld[3], b_wr[3], b_ovf[3], b_ldt[3];
  logic [2:0] b_cls[3];
  logic [3:0] b_dst[3];
  logic [3:0] b_src[3][2], b_agr[3][2];
  logic       b_srcv[3][2], b_agrv[3][2];
  logic       b_trap;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      in_vld[k] = b_vld[k];
      in_wr[k]  = b_wr[k];
      in_ovf[k] = b_ovf[k];
      in_ldt[k] = b_ldt[k];
      in_cls[k*3 +: 3] = b_cls[k];
      in_dst[k*4 +: 4] = b_dst[k];
      for (int s = 0; s < 2; s++) begin
        in_src[(k*2+s)*4 +: 4] = b_src[k][s];
        in_srcv[k*2+s]         = b_srcv[k][s];
        in_agr[(k*2+s)*4 +: 4] = b_agr[k][s];
        in_agrv[k*2+s]         = b_agrv[k][s];
      end
    end
    ovf_trap_en = b_trap;
  end

  issue_grouper u_issue_grouper (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_cls(in_cls), .in_dst(in_dst), .in_wr(in_wr),
    .in_src(in_src), .in_srcv(in_srcv), .in_agr(in_agr), .in_agrv(in_agrv),
    .in_ovf(in_ovf), .in_ldt(in_ldt), .ovf_trap_en(ovf_trap_en),
    .grp_size(grp_size), .issue_en(issue_en), .fwd_sel(fwd_sel), .cc_fwd(cc_fwd)
  );

  task automatic clear_all();
    for (int k = 0; k < 3; k++) begin
      b_vld[k] = 0; b_wr[k] = 0; b_ovf[k] = 0; b_ldt[k] = 0;
      b_cls[k] = 0; b_dst[k] = 0;
      for (int s = 0; s < 2; s++) begin
        b_src[k][s] = 0; b_srcv[k][s] = 0; b_agr[k][s] = 0; b_agrv[k][s] = 0;
      end
    end
    b_trap = 0;
  endtask

  task automatic put(int k, logic [2:0] c, logic [3:0] d, logic w);
    b_vld[k] = 1; b_cls[k] = c; b_dst[k] = d; b_wr[k] = w;
  endtask

  task automatic rd(int k, int s, logic [3:0] r);
    b_src[k][s] = r; b_srcv[k][s] = 1;
  endtask

  task automatic ag(int k, int a, logic [3:0] r);
    b_agr[k][a] = r; b_agrv[k][a] = 1;
  endtask

  // reference: walk the queue from the oldest slot, stop at the first refusal
  function automatic void model(output logic [1:0] sz, output logic [2:0] en,
                                output logic [17:0] fw, output logic cc);
    int stores;
    int count;
    stores = 0; count = 0;
    en = 0; fw = 0; cc = 0;
    for (int k = 0; k < 3; k++) begin
      bit take;
      logic [17:0] f_k;
      bit c_k;
      if (!b_vld[k]) break;
      take = 1; f_k = 0; c_k = 0;
      if (k > 0) begin
        if (b_cls[k] == 3 || b_cls[k] >= 4 || b_cls[0] >= 4) take = 0;
        if (b_cls[k] == 2 && stores > 0) take = 0;
        for (int j = 0; j < k; j++)
          for (int a = 0; a < 2; a++)
            if (b_agrv[k][a] && b_wr[j] && b_dst[j] == b_agr[k][a]) take = 0;
        for (int s = 0; s < 2; s++) begin
          int p;
          p = -1;
          if (b_srcv[k][s])
            for (int j = k - 1; j >= 0; j--)
              if (b_wr[j] && b_dst[j] == b_src[k][s]) begin p = j; break; end
          if (p >= 0) begin
            if (b_cls[p] == 1) f_k[(k*2+s)*3 + p] = 1'b1;
            else if (b_ldt[k] && b_ovf[p] && !b_trap) c_k = 1;
            else take = 0;
          end
        end
      end
      if (!take) break;
      en[k] = 1'b1;
      count++;
      fw = fw | f_k;
      cc = cc | c_k;
      if (b_cls[k] == 2) stores++;
    end
    sz = 2'(count);
  endfunction

  task automatic step(string tag);
    logic [1:0] es; logic [2:0] ee; logic [17:0] ef; logic ec;
    model(es, ee, ef, ec);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (grp_size !== es || issue_en !== ee || fwd_sel !== ef || cc_fwd !== ec) begin
      errors++;
      $display("FAIL %s: size=%0d en=%b fwd=%h cc=%b expected size=%0d en=%b fwd=%h cc=%b",
               tag, grp_size, issue_en, fwd_sel, cc_fwd, es, ee, ef, ec);
    end
  endtask

  task automatic want(string tag, int sz, logic [17:0] fw, logic cc);
    checks++;
    if (grp_size !== 2'(sz) || fwd_sel !== fw || cc_fwd !== cc) begin
      errors++;
      $display("FAIL %s: size=%0d fwd=%h cc=%b expected size=%0d fwd=%h cc=%b",
               tag, grp_size, fwd_sel, cc_fwd, sz, fw, cc);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_all();
    put(0, 0, 1, 1); put(1, 0, 2, 1); put(2, 0, 3, 1);
    repeat (3) @(negedge clk);
    // R1: reset holds outputs at zero despite valid inputs
    checks++;
    if (grp_size !== 0 || issue_en !== 0 || fwd_sel !== 0 || cc_fwd !== 0) begin
      errors++;
      $display("FAIL R1 reset: size=%0d en=%b expected size=0 en=000", grp_size, issue_en);
    end
    rst_n = 1'b1;

    clear_all(); step("R1 empty"); want("R1 empty", 0, 0, 0);
    clear_all(); put(1, 0, 2, 1); put(2, 0, 3, 1);
    step("R11 head invalid"); want("R11 head invalid", 0, 0, 0);

    clear_all(); put(0, 0, 1, 1); put(1, 0, 2, 1); put(2, 1, 3, 1);
    step("R2 independent"); want("R2 independent", 3, 0, 0);

    clear_all(); put(0, 3, 0, 0); put(1, 0, 2, 1); put(2, 2, 0, 0);
    step("R3 branch head"); want("R3 branch head", 3, 0, 0);
    clear_all(); put(0, 0, 1, 1); put(1, 3, 0, 0); put(2, 0, 3, 1);
    step("R3 branch young"); want("R3 branch young", 1, 0, 0);

    clear_all(); put(0, 2, 0, 0); put(1, 1, 5, 1); put(2, 2, 0, 0);
    step("R4 two stores"); want("R4 two stores", 2, 0, 0);

    clear_all(); put(0, 0, 5, 1); put(1, 1, 6, 1); ag(1, 1, 5); put(2, 0, 7, 1);
    step("R5 agen interlock"); want("R5 agen interlock", 1, 0, 0);
    clear_all(); put(0, 1, 5, 1); put(1, 0, 6, 1); put(2, 1, 7, 1); ag(2, 0, 5);
    step("R5 agen on load"); want("R5 agen on load", 2, 0, 0);

    clear_all(); put(0, 0, 4, 1); put(1, 0, 6, 1); rd(1, 0, 4);
    step("R6 raw refused"); want("R6 raw refused", 1, 0, 0);

    clear_all(); put(0, 1, 3, 1); put(1, 0, 6, 1); rd(1, 1, 3); put(2, 0, 7, 1);
    step("R7 load forward"); want("R7 load forward", 3, 18'(1) << 9, 0);
    clear_all(); put(0, 1, 2, 1); put(1, 1, 2, 1); put(2, 0, 8, 1); rd(2, 0, 2);
    step("R7 youngest producer"); want("R7 youngest producer", 3, 18'(1) << 13, 0);

    clear_all(); put(0, 0, 4, 1); b_ovf[0] = 1; put(1, 0, 4, 1); b_ldt[1] = 1; rd(1, 0, 4);
    step("R8 cc forward"); want("R8 cc forward", 2, 0, 1);
    b_trap = 1;
    step("R9 cc split"); want("R9 cc split", 1, 0, 0);

    clear_all(); put(0, 4, 1, 1); put(1, 0, 2, 1);
    step("R10 complex head"); want("R10 complex head", 1, 0, 0);
    clear_all(); put(0, 0, 1, 1); put(1, 6, 2, 1); put(2, 0, 3, 1);
    step("R10 unused code"); want("R10 unused code", 1, 0, 0);

    clear_all(); put(0, 0, 4, 1); put(1, 0, 5, 1); rd(1, 1, 4); put(2, 0, 9, 1);
    step("R11 no skip"); want("R11 no skip", 1, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < 3; k++) begin
        b_vld[k] = ($urandom_range(0, 9) != 0);
        b_cls[k] = 3'($urandom_range(0, 6) == 6 ? $urandom_range(4, 7) : $urandom_range(0, 3));
        b_dst[k] = 4'($urandom_range(0, 5));
        b_wr[k]  = 1'($urandom_range(0, 1));
        b_ovf[k] = 1'($urandom_range(0, 1));
        b_ldt[k] = 1'($urandom_range(0, 1));
        for (int s = 0; s < 2; s++) begin
          b_src[k][s]  = 4'($urandom_range(0, 5));
          b_srcv[k][s] = 1'($urandom_range(0, 1));
          b_agr[k][s]  = 4'($urandom_range(0, 5));
          b_agrv[k][s] = ($urandom_range(0, 3) == 0);
        end
      end
      b_trap = 1'($urandom_range(0, 1));
      step("R2 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule